// File: doc/BRIEF.md
# Tagged Geometry Work Distributor

This block sits between a host-side command stream and four downstream geometry engines. Each command accepted from the host is handed to exactly one engine. It carries a sequence tag that the distributor assigns, so that a later reorder stage can put the results back into arrival order after the engines finish out of order.

Every engine port has a one-entry output register. A command accepted on a rising edge appears on its engine's port after that edge. Engine selection follows a mode pin:

- **Rotate mode** serves the engines in a fixed circular turn and waits on the engine whose turn it is.
- **Least-loaded mode** takes the eligible engine whose reported occupancy is smallest.

Back-pressure rules:

- The host side is valid/ready. A command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high.
- `cmd_ready` is combinational. It is low whenever the reorder stage reports that it has no free tags, or when the selected engine cannot take a command.
- Each engine side is valid/ready. Once `eng_valid` is raised, it holds together with its payload and tag until the engine takes it with `eng_ready`.
- An engine's output register counts as able to take a command when it is empty, or when it is being emptied in that same cycle.

Top module: `geom_work_dist`

## Requirements
- R1: After reset no engine port is valid, the tag counter is 0, and the first command accepted in rotate mode goes to engine 0 with tag 0.
- R2: A command accepted on a rising edge appears after that edge on the chosen engine port, with the payload unchanged.
- R3: An engine port that is valid and not taken (`eng_ready` low) keeps `eng_valid`, payload and tag unchanged on the next cycle.
- R4: Accepted commands receive tags 0, 1, 2, … in acceptance order, wrapping from 2^SEQ_W−1 back to 0.
- R5: In rotate mode (`mode_sel`=0) the engine chosen is the one after the engine that received the previous accepted command, in either mode, wrapping from engine 3 to engine 0.
- R6: In rotate mode, when the engine whose turn it is cannot take a command, `cmd_ready` is low even if other engines could.
- R7: In least-loaded mode (`mode_sel`=1) the engine chosen is the eligible engine with the smallest `eng_occ` value. Engine i's occupancy sits in bits [i*OCC_W +: OCC_W].
- R8: In least-loaded mode, when eligible engines tie on the smallest occupancy, the lowest-numbered one is chosen.
- R9: In least-loaded mode, engines that cannot take a command are skipped; `cmd_ready` is low only when no engine can take one.
- R10: While `tag_full` is high, `cmd_ready` is low and no command is accepted.
- R11: An engine port taken by its engine in a cycle can receive a new command in that same cycle, so it presents back-to-back commands without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | 0 = rotate, 1 = least-loaded |
| tag_full | input | 1 | Reorder stage has no free tags |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Distributor can accept a command |
| cmd_data | input | DATA_W | Host command payload |
| eng_occ | input | NUM_ENG*OCC_W | Per-engine occupancy levels |
| eng_ready | input | NUM_ENG | Per-engine ready |
| eng_valid | output | NUM_ENG | Per-engine command valid |
| eng_data | output | NUM_ENG*DATA_W | Per-engine command payload |
| eng_seq | output | NUM_ENG*SEQ_W | Per-engine sequence tag |

## Verification
The bench checks results on two timescales:

- **Same cycle.** `cmd_ready` follows the inputs and state within the cycle. It is checked a short delay after the inputs are driven, which happens just after the falling edge.
- **One cycle later.** A command's payload and tag appear on an engine port one rising edge after acceptance. The engine outputs are therefore compared in the following cycle, well away from either edge, against a bench-side model updated with the same drains and loads.

A held port is compared against the same stored entry on every cycle until its engine takes it. This makes any premature change visible in the first cycle it occurs.

// File: rtl/gwd_pkg.sv
package gwd_pkg;
  typedef enum logic {
    PICK_ROTATE = 1'b0,
    PICK_LEAST  = 1'b1
  } pick_mode_e;
endpackage

// File: rtl/gwd_seq_ctr.sv
module gwd_seq_ctr #(
  parameter int SEQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [SEQ_W-1:0] cur
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cur <= '0;
    else if (inc) cur <= cur + 1'b1;
  end
endmodule

// File: rtl/gwd_rr_pick.sv
module gwd_rr_pick #(
  parameter int NUM_ENG = 4,
  localparam int IDX_W  = $clog2(NUM_ENG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENG-1:0] elig,
  input  logic               adv,
  input  logic [IDX_W-1:0]   grant_idx,
  output logic [IDX_W-1:0]   turn_idx,
  output logic               turn_ok
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (adv) begin
      if (grant_idx == IDX_W'(NUM_ENG-1)) ptr_q <= '0;
      else                                ptr_q <= grant_idx + 1'b1;
    end
  end

  assign turn_idx = ptr_q;
  assign turn_ok  = elig[ptr_q];
endmodule

// File: rtl/gwd_lb_pick.sv
module gwd_lb_pick #(
  parameter int NUM_ENG = 4,
  parameter int OCC_W   = 3,
  localparam int IDX_W  = $clog2(NUM_ENG)
) (
  input  logic [NUM_ENG*OCC_W-1:0] occ,
  input  logic [NUM_ENG-1:0]       elig,
  output logic [IDX_W-1:0]         pick_idx,
  output logic                     pick_ok
);
  logic [OCC_W-1:0] best;

  always_comb begin
    pick_ok  = 1'b0;
    pick_idx = '0;
    best     = '1;
    for (int i = 0; i < NUM_ENG; i++) begin
      if (elig[i] && (!pick_ok || (occ[i*OCC_W +: OCC_W] < best))) begin
        pick_ok  = 1'b1;
        pick_idx = IDX_W'(i);
        best     = occ[i*OCC_W +: OCC_W];
      end
    end
  end
endmodule

// File: rtl/gwd_eng_slot.sv
module gwd_eng_slot #(
  parameter int DATA_W = 16,
  parameter int SEQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [SEQ_W-1:0]  ld_seq,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [SEQ_W-1:0]  out_seq,
  output logic              can_take
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_seq   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_seq   <= ld_seq;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/geom_work_dist.sv
module geom_work_dist #(
  parameter int NUM_ENG = 4,
  parameter int DATA_W  = 16,
  parameter int SEQ_W   = 4,
  parameter int OCC_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_sel,
  input  logic                      tag_full,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [DATA_W-1:0]         cmd_data,
  input  logic [NUM_ENG*OCC_W-1:0]  eng_occ,
  input  logic [NUM_ENG-1:0]        eng_ready,
  output logic [NUM_ENG-1:0]        eng_valid,
  output logic [NUM_ENG*DATA_W-1:0] eng_data,
  output logic [NUM_ENG*SEQ_W-1:0]  eng_seq
);
  import gwd_pkg::*;
  localparam int IDX_W = $clog2(NUM_ENG);

  pick_mode_e         mode;
  logic [NUM_ENG-1:0] elig;
  logic [IDX_W-1:0]   rr_idx, lb_idx, sel_idx;
  logic               rr_ok, lb_ok, sel_ok, accept;
  logic [SEQ_W-1:0]   seq_cur;

  assign mode      = pick_mode_e'(mode_sel);
  assign sel_idx   = (mode == PICK_LEAST) ? lb_idx : rr_idx;
  assign sel_ok    = (mode == PICK_LEAST) ? lb_ok  : rr_ok;
  assign cmd_ready = sel_ok && !tag_full;
  assign accept    = cmd_valid && cmd_ready;

  gwd_seq_ctr #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .inc(accept), .cur(seq_cur)
  );

  gwd_rr_pick #(.NUM_ENG(NUM_ENG)) u_rr (
    .clk(clk), .rst_n(rst_n), .elig(elig), .adv(accept),
    .grant_idx(sel_idx), .turn_idx(rr_idx), .turn_ok(rr_ok)
  );

  gwd_lb_pick #(.NUM_ENG(NUM_ENG), .OCC_W(OCC_W)) u_lb (
    .occ(eng_occ), .elig(elig), .pick_idx(lb_idx), .pick_ok(lb_ok)
  );

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_slot
    logic ld;
    assign ld = accept && (sel_idx == IDX_W'(g));
    gwd_eng_slot #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(ld), .ld_data(cmd_data), .ld_seq(seq_cur),
      .out_ready(eng_ready[g]), .out_valid(eng_valid[g]),
      .out_data(eng_data[g*DATA_W +: DATA_W]), .out_seq(eng_seq[g*SEQ_W +: SEQ_W]),
      .can_take(elig[g])
    );
  end
endmodule

// File: rtl/gwd_chk.sv
module gwd_chk #(
  parameter int NUM_ENG = 4,
  parameter int DATA_W  = 16,
  parameter int SEQ_W   = 4,
  parameter int OCC_W   = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tag_full,
  input logic                      cmd_valid,
  input logic                      cmd_ready,
  input logic [DATA_W-1:0]         cmd_data,
  input logic [NUM_ENG-1:0]        eng_ready,
  input logic [NUM_ENG-1:0]        eng_valid,
  input logic [NUM_ENG*DATA_W-1:0] eng_data,
  input logic [NUM_ENG*SEQ_W-1:0]  eng_seq
);
  logic             acc;
  logic [SEQ_W-1:0] exp_seq;

  assign acc = cmd_valid && cmd_ready && rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n)   exp_seq <= '0;
    else if (acc) exp_seq <= exp_seq + 1'b1;
  end

  // R10
  tag_full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_full |-> !cmd_ready);

  // R9
  ready_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> ((~eng_valid | eng_ready) != '0));

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid[g] && !eng_ready[g]) |=>
        (eng_valid[g] && $stable(eng_data[g*DATA_W +: DATA_W]) &&
         $stable(eng_seq[g*SEQ_W +: SEQ_W])));

    // R4
    load_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc) && eng_valid[g] && (!$past(eng_valid[g]) || $past(eng_ready[g]))) |->
        (eng_seq[g*SEQ_W +: SEQ_W] == $past(exp_seq)));

    // R2
    load_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc) && eng_valid[g] && (!$past(eng_valid[g]) || $past(eng_ready[g]))) |->
        (eng_data[g*DATA_W +: DATA_W] == $past(cmd_data)));
  end
endmodule

bind geom_work_dist gwd_chk #(
  .NUM_ENG(NUM_ENG), .DATA_W(DATA_W), .SEQ_W(SEQ_W), .OCC_W(OCC_W)
) i_gwd_chk (
  .clk(clk), .rst_n(rst_n), .tag_full(tag_full), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_data(cmd_data), .eng_ready(eng_ready),
  .eng_valid(eng_valid), .eng_data(eng_data), .eng_seq(eng_seq)
);

// File: tb/test_geom_work_dist.sv
`timescale 1ns/1ps
module test_geom_work_dist;
  localparam int NE = 4, DW = 16, SW = 4, OW = 3;

  logic clk = 0, rst_n = 0, mode_sel = 0, tag_full = 0, cmd_valid = 0;
  logic cmd_ready;
  logic [DW-1:0] cmd_data = '0;
  logic [NE*OW-1:0] eng_occ = '0;
  logic [NE-1:0] eng_ready = '0, eng_valid;
  logic [NE*DW-1:0] eng_data;
  logic [NE*SW-1:0] eng_seq;

  int errors = 0, checks = 0;
  bit done = 0, first_acc = 1;

  bit          m_full [NE];
  logic [DW-1:0] m_data [NE];
  logic [SW-1:0] m_seq  [NE];
  string       m_tag  [NE];
  int          m_ptr = 0;
  logic [SW-1:0] m_ctr = '0;

  always #2 clk = ~clk;

  geom_work_dist #(.NUM_ENG(NE), .DATA_W(DW), .SEQ_W(SW), .OCC_W(OW)) i_geom_work_dist (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tag_full(tag_full),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .eng_occ(eng_occ), .eng_ready(eng_ready), .eng_valid(eng_valid),
    .eng_data(eng_data), .eng_seq(eng_seq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // least-loaded reference: lowest occupancy among eligible, lowest index on tie
  function automatic int lb_ref(input bit el [NE], output bit tie);
    int best = -1;
    tie = 0;
    for (int i = 0; i < NE; i++)
      if (el[i]) begin
        if (best < 0 || eng_occ[i*OW +: OW] < eng_occ[best*OW +: OW]) best = i;
      end
    if (best >= 0)
      for (int i = best + 1; i < NE; i++)
        if (el[i] && eng_occ[i*OW +: OW] == eng_occ[best*OW +: OW]) tie = 1;
    return best;
  endfunction

  task automatic step(input bit md, input int rdy_pct, input int tf_pct,
                      input int occ_max, input int vld_pct);
    bit el [NE];
    bit tie;
    int tgt;
    bit exp_rdy, refill;
    @(negedge clk);
    mode_sel  = md;
    cmd_valid = ($urandom % 100) < vld_pct;
    cmd_data  = DW'($urandom);
    tag_full  = ($urandom % 100) < tf_pct;
    for (int i = 0; i < NE; i++) begin
      eng_ready[i] = ($urandom % 100) < rdy_pct;
      eng_occ[i*OW +: OW] = OW'($urandom % (occ_max + 1));
    end
    #1;
    for (int i = 0; i < NE; i++) begin
      check(eng_valid[i] == m_full[i], m_full[i] ? m_tag[i] : "R3",
            int'(eng_valid[i]), int'(m_full[i]));
      if (m_full[i]) begin
        check(eng_data[i*DW +: DW] == m_data[i], m_tag[i] == "R3" ? "R3" : "R2",
              int'(eng_data[i*DW +: DW]), int'(m_data[i]));
        check(eng_seq[i*SW +: SW] == m_seq[i], "R4",
              int'(eng_seq[i*SW +: SW]), int'(m_seq[i]));
      end
    end
    for (int i = 0; i < NE; i++) el[i] = !m_full[i] || eng_ready[i];
    tie = 0;
    tgt = md ? lb_ref(el, tie) : (el[m_ptr] ? m_ptr : -1);
    exp_rdy = (tgt >= 0) && !tag_full;
    check(cmd_ready == exp_rdy, tag_full ? "R10" : (md ? "R9" : "R6"),
          int'(cmd_ready), int'(exp_rdy));
    for (int i = 0; i < NE; i++) begin
      if (m_full[i] && !eng_ready[i]) m_tag[i] = "R3";
    end
    refill = 0;
    if (tgt >= 0) refill = m_full[tgt] && eng_ready[tgt];
    for (int i = 0; i < NE; i++) if (m_full[i] && eng_ready[i]) m_full[i] = 0;
    if (cmd_valid && exp_rdy) begin
      m_full[tgt] = 1;
      m_data[tgt] = cmd_data;
      m_seq[tgt]  = m_ctr;
      if (first_acc && !md)  m_tag[tgt] = "R1";
      else if (refill)       m_tag[tgt] = "R11";
      else if (!md)          m_tag[tgt] = "R5";
      else                   m_tag[tgt] = tie ? "R8" : "R7";
      first_acc = 0;
      m_ctr = m_ctr + 1'b1;
      m_ptr = (tgt + 1) % NE;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NE; i++) begin m_full[i] = 0; m_tag[i] = "R3"; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1: no port valid after reset
    check(eng_valid == '0, "R1", int'(eng_valid), 0);
    // R1/R5: rotate with everything ready, first grant engine 0
    repeat (40)  step(0, 100, 0, 7, 100);
    // R6: rotate under heavy engine back-pressure
    repeat (300) step(0, 25, 0, 7, 90);
    // R7/R9: least-loaded with spread occupancy
    repeat (300) step(1, 40, 0, 7, 90);
    // R8: all occupancies equal, ties decided by index
    repeat (100) step(1, 50, 0, 0, 90);
    // R10: tag space exhausted
    repeat (30)  step(1, 60, 100, 3, 100);
    repeat (30)  step(0, 60, 100, 3, 100);
    // R11: engines drain every cycle, back-to-back refills
    repeat (60)  step(0, 100, 0, 1, 100);
    repeat (60)  step(1, 100, 0, 1, 100);
    // mixed: random mode switching, R4 wrap many times
    for (int k = 0; k < 1200; k++)
      step(bit'($urandom % 2), 20 + int'($urandom % 70), int'($urandom % 20), 7, 80);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule